// File: doc/BRIEF.md
# Two-Stage Delta-Sigma Decimation Chain

This block turns the one-bit output of a second-order delta-sigma current-sense modulator into 16-bit samples. It works in two decimation stages. The first stage is a small counter that integrates the bit stream and dumps it every 15 modulator clocks. Each dump gives a 4-bit word at the intermediate rate, which is 2 Msps for a 30 MHz modulator clock.

A three-tap median filter cleans the intermediate words. It removes isolated spikes such as those caused by single-event upsets. The cleaned words then drive a third-order CIC decimator that decimates by 128. The CIC result is truncated to its top 16 bits and presented with a one-clock valid strobe and a settled flag.

Every register in the block runs on the modulator clock and uses one synchronous, active-high reset. The first stage does all its work there. The later stages act only on clocks that carry an enable strobe.

Top module: `dsDecimChain`

## Requirements
- R1: `midWord` holds the number of '1' bits sampled during the 15 clock edges that close with a dump. Consecutive windows share no edge and leave no edge out, so a bit stream with density k/15 yields `midWord` = k for every k from 0 to 15.
- R2: `midValid` is high for one clock in every 15, and for a single clock each time.
- R3: A window made entirely of '1' bits reports 15 without wrapping to 0.
- R4: The filter feeding the second stage is the median of the three most recent intermediate words. A single intermediate word that differs from a constant neighbourhood therefore leaves every final output unchanged.
- R5: One final word is produced for every 128 intermediate words, which is one `outValid` pulse every 1920 clocks.
- R6: `outValid` stays high for exactly one clock for each word.
- R7: `outWord` is the 25-bit third-order CIC result shifted right by 9 and read as unsigned. Once settled, a constant intermediate value k gives `outWord` = k·4096, so all-ones input gives 0xF000 and no output ever exceeds 0xF000.
- R8: `outSettled` is 0 on the first three words after reset and 1 on every later word.
- R9: While reset is applied, the counter, the median history, the integrators, the comb delays and the settle count are all cleared. `midValid`, `outValid`, `midWord`, `outWord` and `outSettled` read 0 one clock later, and a run that follows the reset shows no trace of earlier input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one input bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Modulator data bit |
| midWord | output | 4 | Intermediate sinc1 word (count of ones in the window) |
| midValid | output | 1 | One-clock strobe marking a new `midWord` |
| outWord | output | 16 | Final decimated sample, unsigned |
| outValid | output | 1 | One-clock strobe marking a new `outWord` |
| outSettled | output | 1 | High once the CIC history holds only post-reset data |

## Verification
On every clock the assertions check the following properties:
- the spacing and width of both strobes, measured against window-length counters;
- that the final word never exceeds the 0xF000 ceiling;
- that the settled flag never drops again until a reset;
- that reset clears the outputs.

Only the scenarios in the bench can show that the counts and the CIC gain produce the right values for each input density. The same holds for spike rejection, which needs a sequence of intermediate words and not a single cycle. The bench also shows that a mid-run reset erases the integrator and comb history.

// File: rtl/dsDecimPkg.sv
package dsDecimPkg;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic dump;     // close the current sinc1 window on this edge
    logic combEn;   // run the comb section and register the output
    logic settled;  // the word being registered is past the settle span
  } decimCtl_t;

  // Median of three unsigned values.
  function automatic logic [3:0] median3(input logic [3:0] a,
                                         input logic [3:0] b,
                                         input logic [3:0] c);
    logic [3:0] lo;
    logic [3:0] hi;
    logic [3:0] mid;
    lo  = (a < b) ? a : b;
    hi  = (a < b) ? b : a;
    mid = (hi < c) ? hi : c;
    return (lo > mid) ? lo : mid;
  endfunction

endpackage

// File: rtl/dsDecimCtl.sv
module dsDecimCtl
  import dsDecimPkg::*;
#(
  parameter int DUMP_LEN    = 15,
  parameter int DECIM       = 128,
  parameter int SETTLE_OUTS = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      medValid,
  output decimCtl_t ctl
);
  localparam int PH_W = $clog2(DUMP_LEN);
  localparam int DC_W = $clog2(DECIM);
  localparam int ST_W = $clog2(SETTLE_OUTS + 1);

  logic [PH_W-1:0] phase;
  logic [DC_W-1:0] decCnt;
  logic [ST_W-1:0] outCount;
  logic            decimEvt;
  logic            combEnQ;

  assign decimEvt = medValid && (decCnt == DC_W'(DECIM - 1));

  // Phase counter for the first stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == PH_W'(DUMP_LEN - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // Counts filtered words and raises the comb enable one clock after the
  // integrators have taken in the last word of a block.
  always_ff @(posedge clk) begin
    if (rst) begin
      decCnt  <= '0;
      combEnQ <= 1'b0;
    end else begin
      combEnQ <= decimEvt;
      if (medValid) decCnt <= decCnt + 1'b1;
    end
  end

  // Saturating count of words produced since reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      outCount <= '0;
    end else if (combEnQ && (outCount != ST_W'(SETTLE_OUTS))) begin
      outCount <= outCount + 1'b1;
    end
  end

  always_comb begin
    ctl.dump    = (phase == PH_W'(DUMP_LEN - 1));
    ctl.combEn  = combEnQ;
    ctl.settled = (outCount == ST_W'(SETTLE_OUTS));
  end

endmodule

// File: rtl/dsDecimPath.sv
module dsDecimPath
  import dsDecimPkg::*;
#(
  parameter int MID_W      = 4,
  parameter int OUT_W      = 16,
  parameter int ORDER      = 3,
  parameter int DECIM_LOG2 = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitIn,
  input  decimCtl_t        ctl,
  output logic [MID_W-1:0] midWord,
  output logic             midValid,
  output logic             medValid,
  output logic [OUT_W-1:0] outWord,
  output logic             outValid,
  output logic             outSettled
);
  localparam int CIC_W = MID_W + ORDER * DECIM_LOG2;

  // ---------------- sinc1 counter ----------------
  logic [MID_W-1:0] onesCnt;
  logic [MID_W-1:0] onesNext;
  assign onesNext = onesCnt + MID_W'(bitIn);

  always_ff @(posedge clk) begin
    if (rst) begin
      onesCnt  <= '0;
      midWord  <= '0;
      midValid <= 1'b0;
    end else begin
      midValid <= ctl.dump;
      if (ctl.dump) begin
        midWord <= onesNext;
        onesCnt <= '0;
      end else begin
        onesCnt <= onesNext;
      end
    end
  end

  // ---------------- median spike filter ----------------
  logic [MID_W-1:0] hist1;
  logic [MID_W-1:0] hist2;
  logic [MID_W-1:0] medWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1    <= '0;
      hist2    <= '0;
      medWord  <= '0;
      medValid <= 1'b0;
    end else begin
      medValid <= midValid;
      if (midValid) begin
        medWord <= median3(midWord, hist1, hist2);
        hist2   <= hist1;
        hist1   <= midWord;
      end
    end
  end

  // ---------------- CIC integrators ----------------
  logic [CIC_W-1:0] integ [ORDER];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ORDER; j++) integ[j] <= '0;
    end else if (medValid) begin
      integ[0] <= integ[0] + CIC_W'(medWord);
      for (int j = 1; j < ORDER; j++) integ[j] <= integ[j] + integ[j-1];
    end
  end

  // ---------------- CIC combs ----------------
  logic [CIC_W-1:0] stage [ORDER+1];
  logic [CIC_W-1:0] dly   [ORDER];

  assign stage[0] = integ[ORDER-1];
  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    assign stage[g+1] = stage[g] - dly[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ORDER; j++) dly[j] <= '0;
      outWord    <= '0;
      outValid   <= 1'b0;
      outSettled <= 1'b0;
    end else begin
      outValid <= ctl.combEn;
      if (ctl.combEn) begin
        for (int j = 0; j < ORDER; j++) dly[j] <= stage[j];
        outWord    <= stage[ORDER][CIC_W-1 -: OUT_W];
        outSettled <= ctl.settled;
      end
    end
  end

endmodule

// File: rtl/dsDecimChain.sv
module dsDecimChain
  import dsDecimPkg::*;
#(
  parameter int DUMP_LEN = 15,
  parameter int DECIM    = 128,
  parameter int ORDER    = 3,
  parameter int OUT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitIn,
  output logic [3:0]       midWord,
  output logic             midValid,
  output logic [OUT_W-1:0] outWord,
  output logic             outValid,
  output logic             outSettled
);
  localparam int MID_W      = $clog2(DUMP_LEN + 1);
  localparam int DECIM_LOG2 = $clog2(DECIM);

  decimCtl_t ctl;
  logic      medValid;

  dsDecimCtl #(
    .DUMP_LEN   (DUMP_LEN),
    .DECIM      (DECIM),
    .SETTLE_OUTS(ORDER)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .medValid(medValid),
    .ctl     (ctl)
  );

  dsDecimPath #(
    .MID_W     (MID_W),
    .OUT_W     (OUT_W),
    .ORDER     (ORDER),
    .DECIM_LOG2(DECIM_LOG2)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .bitIn     (bitIn),
    .ctl       (ctl),
    .midWord   (midWord),
    .midValid  (midValid),
    .medValid  (medValid),
    .outWord   (outWord),
    .outValid  (outValid),
    .outSettled(outSettled)
  );

endmodule

// File: rtl/dsDecimChain_chk.sv
module dsDecimChain_chk #(
  parameter int DUMP_LEN = 15,
  parameter int DECIM    = 128,
  parameter int OUT_W    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             midValid,
  input logic             outValid,
  input logic [OUT_W-1:0] outWord,
  input logic             outSettled
);
  int unsigned midGap;
  int unsigned outGap;
  logic        midSeen;
  logic        outSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      midGap  <= 0;
      outGap  <= 0;
      midSeen <= 1'b0;
      outSeen <= 1'b0;
    end else begin
      if (midValid) begin
        midGap  <= 0;
        midSeen <= 1'b1;
      end else begin
        midGap <= midGap + 1;
      end
      if (outValid) begin
        outGap  <= 0;
        outSeen <= 1'b1;
      end else begin
        outGap <= outGap + 1;
      end
    end
  end

  // R2
  mid_period_chk: assert property (@(posedge clk) disable iff (rst)
    (midValid && midSeen) |-> (midGap == DUMP_LEN - 1));

  // R2
  mid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    midValid |=> !midValid);

  // R5
  out_period_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outSeen) |-> (outGap == DUMP_LEN * DECIM - 1));

  // R6
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R7
  out_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outWord <= OUT_W'(16'hF000)));

  // R8
  settled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    outSettled |=> outSettled);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!midValid && !outValid && (outWord == '0) && !outSettled));

endmodule

bind dsDecimChain dsDecimChain_chk #(
  .DUMP_LEN(DUMP_LEN),
  .DECIM   (DECIM),
  .OUT_W   (OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .midValid  (midValid),
  .outValid  (outValid),
  .outWord   (outWord),
  .outSettled(outSettled)
);

// File: tb/dsDecimChain_tb.sv
module dsDecimChain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 15;
  localparam int WD_CYCLES  = 150000;
  localparam int NVEC       = 5;
  // {density k, expected settled output}
  localparam logic [19:0] VECS [NVEC] = '{
    {4'd0,  16'd0},
    {4'd1,  16'd4096},
    {4'd7,  16'd28672},
    {4'd8,  16'd32768},
    {4'd15, 16'd61440}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitIn;
  logic [3:0]  midWord;
  logic        midValid;
  logic [15:0] outWord;
  logic        outValid;
  logic        outSettled;

  int checks   = 0;
  int failures = 0;
  int density  = 0;
  int forceCnt = 0;
  int patPos   = 0;
  bit glitchReq = 1'b0;

  dsDecimChain u_dut (
    .clk       (clk),
    .rst       (rst),
    .bitIn     (bitIn),
    .midWord   (midWord),
    .midValid  (midValid),
    .outWord   (outWord),
    .outValid  (outValid),
    .outSettled(outSettled)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Stimulus driver: periodic pattern of density/15, with an optional forced
  // all-ones window aligned to the window after a midValid pulse.
  initial begin
    bitIn = 1'b0;
    forever begin
      @(negedge clk);
      if (glitchReq && midValid) begin
        forceCnt  = WINDOW;
        glitchReq = 1'b0;
      end
      if (forceCnt > 0) begin
        bitIn = 1'b1;
        forceCnt--;
      end else begin
        bitIn = (patPos < density);
      end
      patPos = (patPos + 1) % WINDOW;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitOut(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (outValid !== 1'b1);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!midValid && !outValid && !outSettled, "R9 strobes/flag in reset",
        {midValid, outValid, outSettled}, 0);
    chk(outWord == 16'd0 && midWord == 4'd0, "R9 words in reset",
        int'(outWord) + int'(midWord), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    int gap;

    // Table of densities: R1, R3, R5, R7, R8
    for (int v = 0; v < NVEC; v++) begin
      density = int'(VECS[v][19:16]);
      doReset();
      for (int n = 0; n < 4; n++) begin
        waitOut(cyc);
        if (n < 3) chk(outSettled == 1'b0, "R8 early word flagged", outSettled, 0);
        if (v == 0 && n == 1) chk(cyc == 1920, "R5 output period", cyc, 1920);
      end
      chk(outSettled == 1'b1, "R8 fourth word settled", outSettled, 1);
      chk(outWord == VECS[v][15:0], "R7 settled output", outWord, int'(VECS[v][15:0]));
      chk(int'(midWord) == density, "R1 window count", midWord, density);
      if (density == 15) chk(midWord == 4'd15, "R3 full window no wrap", midWord, 15);
    end

    // R2: intermediate strobe period and width
    do @(negedge clk); while (!midValid);
    @(negedge clk);
    chk(!midValid, "R2 strobe width", midValid, 0);
    gap = 1;
    do begin @(negedge clk); gap++; end while (!midValid);
    chk(gap == 15, "R2 strobe period", gap, 15);

    // R6: output strobe width
    waitOut(cyc);
    @(negedge clk);
    chk(!outValid, "R6 output strobe width", outValid, 0);

    // R4: lone spike rejected by the median
    density = 5;
    doReset();
    for (int n = 0; n < 4; n++) waitOut(cyc);
    chk(outWord == 16'd20480, "R4 baseline", outWord, 20480);
    glitchReq = 1'b1;
    wait (glitchReq == 1'b0);
    @(negedge clk);
    do @(negedge clk); while (!midValid);
    chk(midWord == 4'd15, "R3 forced window counts 15", midWord, 15);
    for (int n = 0; n < 3; n++) begin
      waitOut(cyc);
      chk(outWord == 16'd20480, "R4 spike rejected", outWord, 20480);
    end

    // R9: mid-run reset erases all history
    density = 15;
    doReset();
    waitOut(cyc);
    waitOut(cyc);
    repeat (400) @(negedge clk);
    density = 0;
    doReset();
    for (int n = 0; n < 2; n++) begin
      waitOut(cyc);
      chk(outWord == 16'd0, "R9 no residue after reset", outWord, 0);
      chk(outSettled == 1'b0, "R9 settle count cleared", outSettled, 0);
    end
    chk(midWord == 4'd0, "R9 counter cleared", midWord, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule